// File: doc/BRIEF.md
# Card Attribute-Space Write Port

This block is the slave for the attribute and configuration space of a removable memory card. A fast core clock oversamples the host's card-enable, output-enable, write-enable, register-select, address and data lines. Each host strobe cycle is rebuilt from those samples. A configuration write goes out as a single-cycle write on an internal register-file port. A read drives the addressed byte back with an output enable. Every write is also timed against the attribute-space limits: write pulse width, address setup, data setup, data hold and address recovery. Any rule that is broken is recorded in a sticky flag register.

All host lines pass through one synchronizer of `SYNC_STAGES` flops, so every time in this brief is counted in core-clock samples. The defaults assume an 8 ns core clock. With that clock, a 60 ns write pulse is 8 samples, 40 ns of data setup is 5 samples, and the read drive and release latency of 3 samples (24 ns) stays inside the 50 ns budget. Only even attribute addresses hold configuration bytes. The register file sits outside the block and is read combinationally through `rf_rd_idx`/`rf_rd_data`.

Top module: `attr_cfg_port`

## Requirements
- R1: After reset, `host_doe`, `host_dout`, `viol_flags` and `rf_wr_en` are all zero.
- R2: The block issues exactly one write, with `rf_wr_en` high for one cycle, when a sampled write-enable rising edge occurs while all of the following hold: the card is selected (card-enable low and register-select low), the address is even and below 2*`REG_COUNT`, and all three measured rules of R5 to R7 are met. The write goes to index address[IDX_W:1] and carries the data word from the last sample taken while write-enable was low.
- R3: An odd address or an address at or above 2*`REG_COUNT` produces no write. A read from such an address is driven with data 0x00.
- R4: While the card is selected and write-enable is high, `host_doe` rises `SYNC_STAGES`+1 clock edges after output-enable falls, and `host_dout` then shows the addressed byte. `host_doe` falls `SYNC_STAGES`+1 edges after output-enable or card-enable rises. `host_dout` is zero whenever `host_doe` is low.
- R5: A write-enable low pulse shorter than `WE_MIN_CYC` samples sets flag bit 0 and suppresses the write. A pulse of exactly `WE_MIN_CYC` samples is accepted.
- R6: An address that is not stable for `ADDR_SU_CYC` samples before write-enable falls, or that changes while write-enable is low, sets flag bit 1 and suppresses the write.
- R7: Data that is stable for fewer than `DATA_SU_CYC` samples before write-enable rises sets flag bit 2 and suppresses the write.
- R8: Data that changes in the rising-edge sample or in the following `DATA_HOLD_CYC`-1 samples sets flag bit 3. The write still takes place with the captured word.
- R9: An address that changes in the rising-edge sample or in the following `RECOV_CYC`-1 samples sets flag bit 4. The write still takes place.
- R10: Output-enable and write-enable low together while the card is selected sets flag bit 5. No read is driven during that overlap.
- R11: Flag bits stay set until `viol_clr` is asserted. A one-cycle `viol_clr` returns `viol_flags` to zero on the next edge.
- R12: With register-select high, host strobes cause no write, no drive and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce_n | input | 1 | Host card enable, active low |
| host_reg_n | input | 1 | Host attribute-space select, active low |
| host_oe_n | input | 1 | Host output enable (read strobe), active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | ADDR_W | Host byte address |
| host_din | input | DATA_W | Host write data |
| host_dout | output | DATA_W | Read data toward the host |
| host_doe | output | 1 | Read data output enable |
| viol_clr | input | 1 | Clears the sticky violation flags |
| viol_flags | output | 6 | Sticky timing-violation flags (bits per R5 to R10) |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | IDX_W | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |
| rf_rd_idx | output | IDX_W | Register-file read index |
| rf_rd_data | input | DATA_W | Register-file read data |

## Verification
Well-timed writes go to even addresses, to the last even register, to an odd address and to one address just past the register range. Each is followed by a read, which tells real stores apart from rejected ones and shows that neither of the rejected cases aliases onto index 0. Each timing rule is then broken once in isolation: a 7-sample pulse against an 8-sample one, the address moving with the fall, data moving one sample before the rise, and data or address moving with the rise. The resulting flag pattern and the write count show whether a rule suppresses the write or only reports it. Strobe overlap, register-select high, release by card-enable and the drive latency boundary complete the set.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;
    localparam int VIOL_W     = 6;
    localparam int V_PULSE    = 0;
    localparam int V_ASETUP   = 1;
    localparam int V_DSETUP   = 2;
    localparam int V_DHOLD    = 3;
    localparam int V_RECOV    = 4;
    localparam int V_CONFLICT = 5;
endpackage

// File: rtl/attr_sync.sv
module attr_sync #(
    parameter int               WIDTH   = 8,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= RST_VAL;
                    else        q <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= RST_VAL;
                    else        q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    assign d_out = g_stage[STAGES-1].q;
endmodule

// File: rtl/attr_write_chk.sv
module attr_write_chk
    import attr_port_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int IDX_W         = 3,
    parameter int WE_MIN_CYC    = 8,
    parameter int ADDR_SU_CYC   = 2,
    parameter int DATA_SU_CYC   = 5,
    parameter int DATA_HOLD_CYC = 2,
    parameter int RECOV_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              s_we_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_din,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [VIOL_W-1:0] ev
);
    localparam int WCW = $clog2(WE_MIN_CYC + 1);
    localparam int ACW = $clog2(ADDR_SU_CYC + 1);
    localparam int DCW = $clog2(DATA_SU_CYC + 1);
    localparam int HCW = $clog2(DATA_HOLD_CYC + 1);
    localparam int RCW = $clog2(RECOV_CYC + 1);
    localparam logic [WCW-1:0] WE_MIN_L = WCW'(WE_MIN_CYC);
    localparam logic [ACW-1:0] A_SAT    = ACW'(ADDR_SU_CYC);
    localparam logic [ACW-1:0] A_NEED   = ACW'(ADDR_SU_CYC - 1);
    localparam logic [DCW-1:0] D_SAT    = DCW'(DATA_SU_CYC);
    localparam logic [DCW-1:0] D_NEED   = DCW'(DATA_SU_CYC - 1);
    localparam logic [HCW-1:0] HOLD_M1  = HCW'(DATA_HOLD_CYC - 1);
    localparam logic [RCW-1:0] REC_M1   = RCW'(RECOV_CYC - 1);

    typedef struct packed {
        logic              we_low;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
        logic [WCW-1:0]    low_cnt;
        logic [ACW-1:0]    a_cnt;
        logic [DCW-1:0]    d_cnt;
        logic              a_ok;
        logic [HCW-1:0]    hold_left;
        logic [RCW-1:0]    rec_left;
        logic [ADDR_W-1:0] cap_addr;
        logic [DATA_W-1:0] cap_din;
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
        logic [VIOL_W-1:0] ev;
    } wchk_t;

    wchk_t st_q, st_d;
    logic  fall, rise, a_chg, d_chg, pulse_ok, dsu_ok, hit;

    always_comb begin
        st_d     = st_q;
        fall     = !s_we_n && !st_q.we_low;
        rise     = s_we_n && st_q.we_low;
        a_chg    = s_addr != st_q.addr;
        d_chg    = s_din != st_q.din;
        pulse_ok = st_q.low_cnt >= WE_MIN_L;
        dsu_ok   = st_q.d_cnt >= D_NEED;
        hit      = !st_q.addr[0] && (st_q.addr[ADDR_W-1:IDX_W+1] == '0);

        st_d.we_low = !s_we_n;
        st_d.addr   = s_addr;
        st_d.din    = s_din;
        st_d.a_cnt  = a_chg ? '0 : ((st_q.a_cnt == A_SAT) ? st_q.a_cnt : st_q.a_cnt + 1'b1);
        st_d.d_cnt  = d_chg ? '0 : ((st_q.d_cnt == D_SAT) ? st_q.d_cnt : st_q.d_cnt + 1'b1);

        if (fall) begin
            st_d.low_cnt = WCW'(1);
            st_d.a_ok    = !a_chg && (st_q.a_cnt >= A_NEED);
        end else if (!s_we_n) begin
            if (st_q.low_cnt != WE_MIN_L) st_d.low_cnt = st_q.low_cnt + 1'b1;
            if (a_chg) st_d.a_ok = 1'b0;
        end

        st_d.wr_en = 1'b0;
        st_d.ev    = '0;
        if (rise && sel) begin
            st_d.ev[V_PULSE]  = !pulse_ok;
            st_d.ev[V_ASETUP] = !st_q.a_ok;
            st_d.ev[V_DSETUP] = !dsu_ok;
            st_d.ev[V_DHOLD]  = d_chg;
            st_d.ev[V_RECOV]  = a_chg;
            st_d.wr_en        = pulse_ok && st_q.a_ok && dsu_ok && hit;
            st_d.wr_idx       = st_q.addr[IDX_W:1];
            st_d.wr_data      = st_q.din;
            st_d.cap_addr     = st_q.addr;
            st_d.cap_din      = st_q.din;
            st_d.hold_left    = HOLD_M1;
            st_d.rec_left     = REC_M1;
        end else begin
            if (st_q.hold_left != '0) begin
                st_d.ev[V_DHOLD] = s_din != st_q.cap_din;
                st_d.hold_left   = st_q.hold_left - 1'b1;
            end
            if (st_q.rec_left != '0) begin
                st_d.ev[V_RECOV] = s_addr != st_q.cap_addr;
                st_d.rec_left    = st_q.rec_left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.wr_en;
    assign wr_idx  = st_q.wr_idx;
    assign wr_data = st_q.wr_data;
    assign ev      = st_q.ev;

    // R2
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |=> !st_q.wr_en);
endmodule

// File: rtl/attr_read_drv.sv
module attr_read_drv #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              s_oe_n,
    input  logic              s_we_n,
    input  logic [ADDR_W-1:0] s_addr,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_data,
    output logic              doe,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] dout;
    } rdrv_t;

    rdrv_t st_q, st_d;
    logic  hit;

    assign rd_idx = s_addr[IDX_W:1];

    always_comb begin
        hit        = !s_addr[0] && (s_addr[ADDR_W-1:IDX_W+1] == '0);
        st_d.drive = sel && !s_oe_n && s_we_n;
        st_d.dout  = (st_d.drive && hit) ? rd_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign doe  = st_q.drive;
    assign dout = st_q.dout;

    // R4
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_oe_n) && sel && s_we_n) |=> doe);
    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_oe_n) |=> !doe);
    // R4
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !doe |-> (dout == '0));
endmodule

// File: rtl/attr_cfg_port.sv
module attr_cfg_port
    import attr_port_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int REG_COUNT     = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int WE_MIN_CYC    = 8,
    parameter int ADDR_SU_CYC   = 2,
    parameter int DATA_SU_CYC   = 5,
    parameter int DATA_HOLD_CYC = 2,
    parameter int RECOV_CYC     = 2,
    localparam int IDX_W        = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ce_n,
    input  logic              host_reg_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    input  logic              viol_clr,
    output logic [VIOL_W-1:0] viol_flags,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data
);
    localparam int            SW      = 4 + ADDR_W + DATA_W;
    localparam logic [SW-1:0] SYNC_RST = {4'b1111, {(ADDR_W + DATA_W){1'b0}}};

    typedef struct packed {
        logic [VIOL_W-1:0] viol;
    } top_t;

    logic [SW-1:0]     raw_bus, s_bus;
    logic              s_reg_n, s_ce_n, s_oe_n, s_we_n, sel, conflict;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;
    logic [VIOL_W-1:0] wr_ev, new_ev;
    top_t              st_q, st_d;

    assign raw_bus = {host_reg_n, host_ce_n, host_oe_n, host_we_n, host_addr, host_din};

    attr_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_bus), .d_out(s_bus)
    );

    assign {s_reg_n, s_ce_n, s_oe_n, s_we_n, s_addr, s_din} = s_bus;
    assign sel = !s_ce_n && !s_reg_n;

    attr_write_chk #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .WE_MIN_CYC(WE_MIN_CYC), .ADDR_SU_CYC(ADDR_SU_CYC), .DATA_SU_CYC(DATA_SU_CYC),
        .DATA_HOLD_CYC(DATA_HOLD_CYC), .RECOV_CYC(RECOV_CYC)
    ) u_wchk (
        .clk(clk), .rst_n(rst_n), .sel(sel), .s_we_n(s_we_n), .s_addr(s_addr), .s_din(s_din),
        .wr_en(rf_wr_en), .wr_idx(rf_wr_idx), .wr_data(rf_wr_data), .ev(wr_ev)
    );

    attr_read_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdrv (
        .clk(clk), .rst_n(rst_n), .sel(sel), .s_oe_n(s_oe_n), .s_we_n(s_we_n),
        .s_addr(s_addr), .rd_idx(rf_rd_idx), .rd_data(rf_rd_data),
        .doe(host_doe), .dout(host_dout)
    );

    always_comb begin
        conflict             = sel && !s_oe_n && !s_we_n;
        new_ev               = wr_ev;
        new_ev[V_CONFLICT]   = conflict;
        st_d.viol            = (viol_clr ? '0 : st_q.viol) | new_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol_flags = st_q.viol;

    // R11
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_clr |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));
endmodule

// File: tb/attr_cfg_port_bench.sv
module attr_cfg_port_bench;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int REG_N  = 8;
    localparam int IDX_W  = 3;
    localparam logic [ADDR_W-1:0] IDLE_A = 11'h400;

    // vector: addr(11) data(8) expect_write(1) expect_read(8)
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {11'h000, 8'hA5, 1'b1, 8'hA5},
        {11'h002, 8'h3C, 1'b1, 8'h3C},
        {11'h00E, 8'hFF, 1'b1, 8'hFF},
        {11'h001, 8'h77, 1'b0, 8'h00},
        {11'h010, 8'h99, 1'b0, 8'h00},
        {11'h004, 8'h00, 1'b1, 8'h00},
        {11'h006, 8'h81, 1'b1, 8'h81},
        {11'h00C, 8'h42, 1'b1, 8'h42}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, reg_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = IDLE_A;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              doe;
    logic              viol_clr = 1'b0;
    logic [5:0]        flags;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [DATA_W-1:0] bmem [REG_N];
    int                wr_count;
    int                n_chk = 0, n_bad = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    attr_cfg_port u_attr_cfg_port (
        .clk(clk), .rst_n(rst_n), .host_ce_n(ce_n), .host_reg_n(reg_n),
        .host_oe_n(oe_n), .host_we_n(we_n), .host_addr(addr), .host_din(din),
        .host_dout(dout), .host_doe(doe), .viol_clr(viol_clr), .viol_flags(flags),
        .rf_wr_en(wr_en), .rf_wr_idx(wr_idx), .rf_wr_data(wr_data),
        .rf_rd_idx(rd_idx), .rf_rd_data(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) bmem[i] <= '0;
            wr_count <= 0;
        end else if (wr_en) begin
            bmem[wr_idx] <= wr_data;
            wr_count     <= wr_count + 1;
        end
    end
    assign rd_data = bmem[rd_idx];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input int asu, input int wlen, input int dsu,
                            input int hold, input int rec, input logic rn);
        addr  = a;
        din   = (dsu == 0) ? d : ~d;
        ce_n  = 1'b0;
        reg_n = rn;
        tick(asu);
        we_n = 1'b0;
        for (int i = 0; i < wlen; i++) begin
            if (dsu != 0 && wlen - i == dsu) din = d;
            tick(1);
        end
        we_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (k == hold) din = ~d;
            if (k == rec)  addr = IDLE_A;
            tick(1);
        end
        ce_n  = 1'b1;
        reg_n = 1'b1;
        addr  = IDLE_A;
        tick(2);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic rn,
                           input logic exp_drv, input logic [DATA_W-1:0] exp_val,
                           input string req);
        addr  = a;
        ce_n  = 1'b0;
        reg_n = rn;
        tick(1);
        oe_n = 1'b0;
        tick(2);
        chk("R4 drive not before latency", 32'(doe), 32'd0);
        tick(1);
        chk({req, " drive"}, 32'(doe), 32'(exp_drv));
        chk({req, " data"}, 32'(dout), 32'(exp_val));
        oe_n = 1'b1;
        tick(2);
        chk("R4 drive held until latency", 32'(doe), 32'(exp_drv));
        tick(1);
        chk("R4 release", 32'(doe), 32'd0);
        ce_n  = 1'b1;
        reg_n = 1'b1;
        addr  = IDLE_A;
        tick(1);
    endtask

    task automatic clear_flags();
        viol_clr = 1'b1;
        tick(1);
        viol_clr = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 doe", 32'(doe), 32'd0);
        chk("R1 dout", 32'(dout), 32'd0);
        chk("R1 flags", 32'(flags), 32'd0);
        chk("R1 wr_en", 32'(wr_en), 32'd0);

        // table walk: R2 stores, R3 rejected addresses
        for (int v = 0; v < NV; v++) begin
            int wc0;
            wc0 = wr_count;
            do_write(VEC[v][27:17], VEC[v][16:9], 4, 10, 0, 4, 4, 1'b0);
            chk(VEC[v][8] ? "R2 write count" : "R3 no write", 32'(wr_count - wc0), 32'(VEC[v][8]));
            chk("R2 flags clean", 32'(flags), 32'd0);
            do_read(VEC[v][27:17], 1'b0, 1'b1, VEC[v][7:0], VEC[v][8] ? "R2" : "R3");
        end
        do_read(11'h000, 1'b0, 1'b1, 8'hA5, "R3 no alias");

        begin : directed
            int wc0;
            // R5 pulse boundary
            wc0 = wr_count;
            do_write(11'h008, 8'h11, 4, 7, 0, 4, 4, 1'b0);
            chk("R5 short pulse flag", 32'(flags), 32'h01);
            chk("R5 short pulse no write", 32'(wr_count - wc0), 32'd0);
            clear_flags();
            chk("R11 cleared", 32'(flags), 32'd0);
            do_write(11'h008, 8'h22, 4, 8, 0, 4, 4, 1'b0);
            chk("R5 exact pulse flag", 32'(flags), 32'h00);
            chk("R5 exact pulse write", 32'(wr_count - wc0), 32'd1);
            do_read(11'h008, 1'b0, 1'b1, 8'h22, "R5");

            // R6 address setup
            wc0 = wr_count;
            do_write(11'h004, 8'h33, 0, 10, 0, 4, 4, 1'b0);
            chk("R6 setup flag", 32'(flags), 32'h02);
            chk("R6 no write", 32'(wr_count - wc0), 32'd0);
            clear_flags();

            // R7 data setup
            do_write(11'h004, 8'h44, 4, 10, 1, 4, 4, 1'b0);
            chk("R7 setup flag", 32'(flags), 32'h04);
            chk("R7 no write", 32'(wr_count - wc0), 32'd0);
            do_read(11'h004, 1'b0, 1'b1, 8'h00, "R7");
            clear_flags();

            // R8 data hold
            do_write(11'h00A, 8'h5C, 4, 10, 0, 0, 4, 1'b0);
            chk("R8 hold flag", 32'(flags), 32'h08);
            chk("R8 write kept", 32'(wr_count - wc0), 32'd1);
            do_read(11'h00A, 1'b0, 1'b1, 8'h5C, "R8");
            clear_flags();

            // R9 address recovery
            do_write(11'h00C, 8'h6D, 4, 10, 0, 4, 0, 1'b0);
            chk("R9 recovery flag", 32'(flags), 32'h10);
            chk("R9 write kept", 32'(wr_count - wc0), 32'd2);
            do_read(11'h00C, 1'b0, 1'b1, 8'h6D, "R9");
            clear_flags();

            // R10 strobe overlap (3-sample pulse also trips R5)
            wc0   = wr_count;
            addr  = 11'h008;
            ce_n  = 1'b0;
            reg_n = 1'b0;
            tick(3);
            oe_n = 1'b0;
            we_n = 1'b0;
            tick(3);
            chk("R10 no drive in overlap", 32'(doe), 32'd0);
            oe_n = 1'b1;
            we_n = 1'b1;
            tick(6);
            ce_n  = 1'b1;
            reg_n = 1'b1;
            addr  = IDLE_A;
            tick(2);
            chk("R10 conflict flag", 32'(flags), 32'h21);
            chk("R10 no write", 32'(wr_count - wc0), 32'd0);

            // R11 sticky across a clean write
            do_write(11'h002, 8'h7E, 4, 10, 0, 4, 4, 1'b0);
            chk("R11 sticky", 32'(flags), 32'h21);
            clear_flags();
            chk("R11 clear", 32'(flags), 32'd0);

            // R12 register-select high
            wc0 = wr_count;
            do_write(11'h002, 8'h13, 4, 10, 0, 4, 4, 1'b1);
            chk("R12 no write", 32'(wr_count - wc0), 32'd0);
            chk("R12 no flag", 32'(flags), 32'd0);
            do_read(11'h002, 1'b1, 1'b0, 8'h00, "R12");
            do_read(11'h002, 1'b0, 1'b1, 8'h7E, "R12 content kept");

            // R4 release by card enable
            addr  = 11'h002;
            ce_n  = 1'b0;
            reg_n = 1'b0;
            tick(1);
            oe_n = 1'b0;
            tick(3);
            chk("R4 driven", 32'(doe), 32'd1);
            ce_n = 1'b1;
            tick(2);
            chk("R4 held before CE latency", 32'(doe), 32'd1);
            tick(1);
            chk("R4 release by CE", 32'(doe), 32'd0);
            chk("R4 dout zero when idle", 32'(dout), 32'd0);
            oe_n  = 1'b1;
            reg_n = 1'b1;
            tick(2);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule